// File: doc/BRIEF.md
# Macro Arithmetic and Logic Unit with Persistent Carry

This block is the datapath arithmetic unit of a small macro-execution core. Each cycle it takes a 5-bit operation code and two 32-bit operands. It returns a 32-bit result on the same cycle, without a register on the path. One flag bit is held in a register between instructions. Add operations write a carry into it, and subtract operations write a borrow into it. The carry-using forms of add and subtract read it back, so a wide sum or difference can be built from a chain of 32-bit steps.

The operation code space is sparse. Codes 0 to 3 are arithmetic and codes 8 to 12 are bitwise logic. Every other code is illegal: it gives a zero result and raises an illegal-operation output. A separate immediate select turns the unit into an add-immediate path. That path adds operand A to a sign-extended 18-bit constant. Instruction decode and register-file access are outside this block. The surrounding core extracts the operation code from bits [21:17] of its instruction word and presents it here.

Top module: `macro_alu`

## Requirements
- R1: With `imm_sel`=0, code 0 gives A+B and code 1 gives A+B+flag, both modulo 2^32. When `flag_we`=1, the flag is loaded with the carry out of bit 31.
- R2: With `imm_sel`=0, code 2 gives A−B and code 3 gives A−B−flag, both modulo 2^32. When `flag_we`=1, the flag is loaded with 1 exactly when the true difference is negative. For code 2 that means A<B as unsigned numbers; for code 3 it means A < B+flag.
- R3: With `imm_sel`=0, the logic codes give: 8 → A XOR B, 9 → A OR B, 10 → A AND B, 11 → A AND (NOT B), 12 → NOT(A AND B).
- R4: Logic codes 8 to 12 never change the flag, whatever the value of `flag_we`.
- R5: With `imm_sel`=0, codes 4 to 7 and 13 to 31 drive `result` to zero and `op_illegal` to 1, and they leave the flag unchanged. Every legal code, and every cycle with `imm_sel`=1, drives `op_illegal` to 0.
- R6: With `imm_sel`=1, `result` is A plus `imm` sign-extended from bit 17. `op_code` is ignored and the flag is unchanged.
- R7: The flag is written only in a cycle where `flag_we`=1, `imm_sel`=0 and the code is 0 to 3. When `flag_we`=0 it holds its value.
- R8: A synchronous active-low reset (`rst_n`=0 at a rising clock edge) clears the flag to 0.
- R9: The flag persists between instructions. Code 0 on the low words followed by code 1 on the high words gives the correct 64-bit sum. Code 2 followed by code 3 gives the correct 64-bit difference.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the flag register updates on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the flag |
| op_code | input | 5 | Operation code (0-3 arithmetic, 8-12 logic, others illegal) |
| imm_sel | input | 1 | 1 selects the add-immediate path |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand |
| imm | input | 18 | Signed immediate for the add-immediate path |
| flag_we | input | 1 | Allows an arithmetic code to write the flag |
| result | output | 32 | Combinational result |
| op_illegal | output | 1 | 1 when `op_code` is illegal and `imm_sel`=0 |

## Verification
Assertions check the following on every cycle:
- an illegal code forces a zero result;
- the immediate path never reports an illegal code;
- NAND matches its definition;
- the flag holds whenever the write conditions are not met;
- plain add and subtract leave the correct carry or borrow one edge later;
- reset clears the flag.

The flag has no output port, so its value after each step can only be seen through the bench's scenarios. The bench reads it back with an add-with-carry of zero and zero. The same holds for the results of the carry-consuming codes 1 and 3, for the full sweep over codes and operand corners, and for the chained 64-bit add and subtract.

// File: rtl/macro_alu_pkg.sv
// Package: shared operation codes and operation classes for the macro ALU.
// Assumes a 5-bit operation code; codes not listed here are illegal.
package macro_alu_pkg;

    localparam int OP_W = 5;

    localparam logic [OP_W-1:0] OPC_ADD  = 5'd0;
    localparam logic [OP_W-1:0] OPC_ADC  = 5'd1;
    localparam logic [OP_W-1:0] OPC_SUB  = 5'd2;
    localparam logic [OP_W-1:0] OPC_SBB  = 5'd3;
    localparam logic [OP_W-1:0] OPC_XOR  = 5'd8;
    localparam logic [OP_W-1:0] OPC_OR   = 5'd9;
    localparam logic [OP_W-1:0] OPC_AND  = 5'd10;
    localparam logic [OP_W-1:0] OPC_ANDN = 5'd11;
    localparam logic [OP_W-1:0] OPC_NAND = 5'd12;

    // Selector inside the logic unit (low three bits of the logic codes)
    typedef enum logic [2:0] {
        LSEL_XOR  = 3'd0,
        LSEL_OR   = 3'd1,
        LSEL_AND  = 3'd2,
        LSEL_ANDN = 3'd3,
        LSEL_NAND = 3'd4
    } logic_sel_e;

    typedef enum logic [1:0] {
        CLS_ARITH = 2'd0,
        CLS_LOGIC = 2'd1,
        CLS_BAD   = 2'd2
    } op_class_e;

endpackage

// File: rtl/macro_alu_decode.sv
// Module: macro_alu_decode
// Turns the sparse 5-bit operation code into a class, add/subtract
// controls and a logic selector. Purely combinational.
// Assumes: any code not named in the package is illegal.
module macro_alu_decode
    import macro_alu_pkg::*;
(
    input  logic [OP_W-1:0] op_code,
    output op_class_e       op_class,
    output logic            is_sub,
    output logic            use_flag,
    output logic_sel_e      lsel
);

    // Map each code to its class and controls
    always_comb begin
        op_class = CLS_BAD;
        is_sub   = 1'b0;
        use_flag = 1'b0;
        lsel     = LSEL_XOR;
        case (op_code)
            OPC_ADD:  op_class = CLS_ARITH;
            OPC_ADC: begin
                op_class = CLS_ARITH;
                use_flag = 1'b1;
            end
            OPC_SUB: begin
                op_class = CLS_ARITH;
                is_sub   = 1'b1;
            end
            OPC_SBB: begin
                op_class = CLS_ARITH;
                is_sub   = 1'b1;
                use_flag = 1'b1;
            end
            OPC_XOR: begin
                op_class = CLS_LOGIC;
                lsel     = LSEL_XOR;
            end
            OPC_OR: begin
                op_class = CLS_LOGIC;
                lsel     = LSEL_OR;
            end
            OPC_AND: begin
                op_class = CLS_LOGIC;
                lsel     = LSEL_AND;
            end
            OPC_ANDN: begin
                op_class = CLS_LOGIC;
                lsel     = LSEL_ANDN;
            end
            OPC_NAND: begin
                op_class = CLS_LOGIC;
                lsel     = LSEL_NAND;
            end
            default: op_class = CLS_BAD;
        endcase
    end

endmodule

// File: rtl/macro_alu_arith.sv
// Module: macro_alu_arith
// One shared adder for add, add-with-carry, subtract and subtract-with-
// borrow. Subtraction inverts B and complements the carry-in. The flag it
// produces is a carry for additions and a borrow for subtractions.
// Assumes: is_sub/use_flag come from the decoder, flag_q from the register.
module macro_alu_arith #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              is_sub,
    input  logic              use_flag,
    input  logic              flag_q,
    output logic [DATA_W-1:0] sum,
    output logic              flag_next
);

    localparam int SUM_W = DATA_W + 1;

    logic [DATA_W-1:0] b_eff;
    logic              cin;
    logic [SUM_W-1:0]  sum_wide;

    // Operand conditioning: invert B and carry-in for subtraction
    always_comb begin
        b_eff = is_sub ? ~b : b;
        cin   = is_sub ? ~(use_flag & flag_q) : (use_flag & flag_q);
    end

    // Full-width addition with carry out
    always_comb begin
        sum_wide = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, cin};
    end

    // Carry for add, borrow (inverted carry) for subtract
    always_comb begin
        sum       = sum_wide[DATA_W-1:0];
        flag_next = is_sub ? ~sum_wide[DATA_W] : sum_wide[DATA_W];
    end

endmodule

// File: rtl/macro_alu_logic.sv
// Module: macro_alu_logic
// Bitwise logic unit with one slice per bit, built by a generate loop.
// Assumes: selector values beyond NAND give zero; the decoder never sends them.
module macro_alu_logic
    import macro_alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic_sel_e        lsel,
    output logic [DATA_W-1:0] y
);

    // Per-bit logic slice
    for (genvar gi = 0; gi < DATA_W; gi++) begin : g_slice
        assign y[gi] = (lsel == LSEL_XOR)  ? (a[gi] ^ b[gi])    :
                       (lsel == LSEL_OR)   ? (a[gi] | b[gi])    :
                       (lsel == LSEL_AND)  ? (a[gi] & b[gi])    :
                       (lsel == LSEL_ANDN) ? (a[gi] & ~b[gi])   :
                       (lsel == LSEL_NAND) ? ~(a[gi] & b[gi])   :
                                             1'b0;
    end

endmodule

// File: rtl/macro_alu_flag.sv
// Module: macro_alu_flag
// The single carry/borrow register that persists between instructions.
// Assumes: synchronous active-low reset; we qualified by the top.
module macro_alu_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic we,
    input  logic d,
    output logic q
);

    // Hold, load or clear the flag on each rising edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= 1'b0;
        end else if (we) begin
            q <= d;
        end
    end

endmodule

// File: rtl/macro_alu.sv
// Module: macro_alu (top)
// Combinational 32-bit ALU for the macro core, with a persistent carry/
// borrow flag and an add-immediate path chosen by imm_sel.
// Assumes: the caller extracts the operation code from the instruction;
// result is valid in the same cycle as the inputs; the flag updates on
// the next rising edge.
module macro_alu
    import macro_alu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [4:0]        op_code,
    input  logic              imm_sel,
    input  logic [DATA_W-1:0] opnd_a,
    input  logic [DATA_W-1:0] opnd_b,
    input  logic [IMM_W-1:0]  imm,
    input  logic              flag_we,
    output logic [DATA_W-1:0] result,
    output logic              op_illegal
);

    localparam int EXT_W = DATA_W - IMM_W;

    op_class_e         dec_class;
    logic              dec_sub;
    logic              dec_use_flag;
    logic_sel_e        dec_lsel;
    logic [DATA_W-1:0] imm_ext;
    logic [DATA_W-1:0] arith_b;
    logic              arith_sub;
    logic              arith_use_flag;
    logic [DATA_W-1:0] arith_sum;
    logic              arith_flag;
    logic [DATA_W-1:0] logic_y;
    logic              carry_we;
    logic              carry_q;

    macro_alu_decode u_decode (
        .op_code  (op_code),
        .op_class (dec_class),
        .is_sub   (dec_sub),
        .use_flag (dec_use_flag),
        .lsel     (dec_lsel)
    );

    // Immediate sign extension and adder operand selection
    always_comb begin
        imm_ext        = {{EXT_W{imm[IMM_W-1]}}, imm};
        arith_b        = imm_sel ? imm_ext : opnd_b;
        arith_sub      = imm_sel ? 1'b0 : dec_sub;
        arith_use_flag = imm_sel ? 1'b0 : dec_use_flag;
    end

    macro_alu_arith #(.DATA_W(DATA_W)) u_arith (
        .a         (opnd_a),
        .b         (arith_b),
        .is_sub    (arith_sub),
        .use_flag  (arith_use_flag),
        .flag_q    (carry_q),
        .sum       (arith_sum),
        .flag_next (arith_flag)
    );

    macro_alu_logic #(.DATA_W(DATA_W)) u_logic (
        .a    (opnd_a),
        .b    (opnd_b),
        .lsel (dec_lsel),
        .y    (logic_y)
    );

    // Flag write qualification: arithmetic codes only, never immediate
    always_comb begin
        carry_we = flag_we && !imm_sel && (dec_class == CLS_ARITH);
    end

    macro_alu_flag u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (carry_we),
        .d     (arith_flag),
        .q     (carry_q)
    );

    // Output selection and illegal-code report
    always_comb begin
        if (imm_sel) begin
            result     = arith_sum;
            op_illegal = 1'b0;
        end else begin
            case (dec_class)
                CLS_ARITH: result = arith_sum;
                CLS_LOGIC: result = logic_y;
                default:   result = '0;
            endcase
            op_illegal = (dec_class == CLS_BAD);
        end
    end

    // R1: plain add leaves the carry out of the top bit
    a_r1_add_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we && !imm_sel && op_code == 5'd0) |=>
        (carry_q == (({1'b0, $past(opnd_a)} + {1'b0, $past(opnd_b)}) >
                     {1'b0, {DATA_W{1'b1}}})));

    // R2: plain subtract leaves an unsigned borrow
    a_r2_sub_borrow: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we && !imm_sel && op_code == 5'd2) |=>
        (carry_q == ($past(opnd_a) < $past(opnd_b))));

    // R3: NAND code matches its definition at the output
    a_r3_nand: assert property (@(posedge clk) disable iff (!rst_n)
        (!imm_sel && op_code == 5'd12) |-> (result == ~(opnd_a & opnd_b)));

    // R4, R5, R6, R7: flag holds when no arithmetic write is allowed
    a_r7_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_we || imm_sel || op_code > 5'd3) |=> $stable(carry_q));

    // R5: an illegal code always gives a zero result
    a_r5_bad_zero: assert property (@(posedge clk) disable iff (!rst_n)
        op_illegal |-> (result == '0));

    // R6: the immediate path never reports an illegal code
    a_r6_imm_legal: assert property (@(posedge clk) disable iff (!rst_n)
        imm_sel |-> !op_illegal);

    // R8: reset clears the flag on the following cycle
    a_r8_reset_clear: assert property (@(posedge clk)
        !rst_n |=> !carry_q);

endmodule

// File: tb/test_macro_alu.sv
// Bench: sweeps every operation code over corner operands and both flag
// states, then the immediate path, chained 64-bit arithmetic and reset.
module test_macro_alu;

    localparam int CLK_PERIOD = 10;

    logic        clk;
    logic        rst_n;
    logic [4:0]  op_code;
    logic        imm_sel;
    logic [31:0] opnd_a;
    logic [31:0] opnd_b;
    logic [17:0] imm;
    logic        flag_we;
    logic [31:0] result;
    logic        op_illegal;

    int errors = 0;
    int checks = 0;
    logic model_flag = 1'b0;

    macro_alu i_macro_alu (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_code    (op_code),
        .imm_sel    (imm_sel),
        .opnd_a     (opnd_a),
        .opnd_b     (opnd_b),
        .imm        (imm),
        .flag_we    (flag_we),
        .result     (result),
        .op_illegal (op_illegal)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: run did not finish, got hung expected done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    function automatic string tag_of(input logic [4:0] op);
        if (op <= 5'd1) return "R1";
        if (op <= 5'd3) return "R2";
        if (op >= 5'd8 && op <= 5'd12) return "R3";
        return "R5";
    endfunction

    task automatic check32(input string tag, input string what,
                           input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
        end
    endtask

    // Apply one operation, check outputs mid-cycle, update the flag model
    task automatic run_op(input logic [4:0] op, input logic [31:0] a,
                          input logic [31:0] b, input logic upd,
                          input logic sel, input logic [17:0] im,
                          input string tag, output logic [31:0] got);
        logic [32:0] wide;
        logic [31:0] exp_r;
        logic        exp_bad;
        logic        nflag;
        logic        write;
        @(negedge clk);
        op_code = op; opnd_a = a; opnd_b = b; flag_we = upd;
        imm_sel = sel; imm = im;
        exp_bad = 1'b0; write = 1'b0; nflag = model_flag; exp_r = '0;
        if (sel) begin
            exp_r = a + {{14{im[17]}}, im};
        end else begin
            case (op)
                5'd0: begin wide = {1'b0, a} + {1'b0, b}; exp_r = wide[31:0];
                            nflag = wide[32]; write = 1'b1; end
                5'd1: begin wide = {1'b0, a} + {1'b0, b} + {32'd0, model_flag};
                            exp_r = wide[31:0]; nflag = wide[32]; write = 1'b1; end
                5'd2: begin exp_r = a - b; nflag = (a < b); write = 1'b1; end
                5'd3: begin exp_r = a - b - {31'd0, model_flag};
                            nflag = ({1'b0, a} < ({1'b0, b} + {32'd0, model_flag}));
                            write = 1'b1; end
                5'd8:  exp_r = a ^ b;
                5'd9:  exp_r = a | b;
                5'd10: exp_r = a & b;
                5'd11: exp_r = a & ~b;
                5'd12: exp_r = ~(a & b);
                default: exp_bad = 1'b1;
            endcase
        end
        #(CLK_PERIOD/4);
        got = result;
        check32(tag, "result", result, exp_r);
        check32(sel ? "R6" : "R5", "op_illegal", {31'd0, op_illegal}, {31'd0, exp_bad});
        @(posedge clk);
        if (write && upd) model_flag = nflag;
    endtask

    // Read the flag back through an add-with-carry of zeros (no write)
    task automatic probe_flag(input string tag);
        logic [31:0] got;
        logic        expf;
        expf = model_flag;
        run_op(5'd1, 32'd0, 32'd0, 1'b0, 1'b0, 18'd0, tag, got);
        check32(tag, "flag readback", got, {31'd0, expf});
    endtask

    task automatic force_flag(input logic f);
        logic [31:0] got;
        if (f) run_op(5'd2, 32'd0, 32'd1, 1'b1, 1'b0, 18'd0, "R2", got);
        else   run_op(5'd2, 32'd1, 32'd0, 1'b1, 1'b0, 18'd0, "R2", got);
    endtask

    logic [31:0] pa [8];
    logic [31:0] pb [8];
    logic [17:0] iv [6];

    initial begin
        logic [31:0] lo;
        logic [31:0] hi;
        logic [63:0] x;
        logic [63:0] y;
        pa[0] = 32'h0000_0000; pb[0] = 32'h0000_0000;
        pa[1] = 32'hFFFF_FFFF; pb[1] = 32'h0000_0001;
        pa[2] = 32'h8000_0000; pb[2] = 32'h8000_0000;
        pa[3] = 32'h0000_0001; pb[3] = 32'h0000_0002;
        pa[4] = 32'h1234_5678; pb[4] = 32'h9ABC_DEF0;
        pa[5] = 32'hFFFF_FFFF; pb[5] = 32'hFFFF_FFFF;
        pa[6] = 32'h7FFF_FFFF; pb[6] = 32'h0000_0001;
        pa[7] = 32'hA5A5_A5A5; pb[7] = 32'h5A5A_5A5A;
        iv[0] = 18'h00000; iv[1] = 18'h00001; iv[2] = 18'h1FFFF;
        iv[3] = 18'h20000; iv[4] = 18'h3FFFF; iv[5] = 18'h15A5A;

        rst_n = 1'b0; op_code = '0; imm_sel = 1'b0; opnd_a = '0;
        opnd_b = '0; imm = '0; flag_we = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_flag = 1'b0;
        probe_flag("R8");

        // R1 R2 R3 R4 R5 R7: every code, every corner pair, both flags, both write enables
        for (int f = 0; f < 2; f++) begin
            for (int op = 0; op < 32; op++) begin
                for (int p = 0; p < 8; p++) begin
                    for (int u = 0; u < 2; u++) begin
                        logic [31:0] got;
                        string t;
                        force_flag(f[0]);
                        t = tag_of(op[4:0]);
                        run_op(op[4:0], pa[p], pb[p], u[0], 1'b0, 18'd0, t, got);
                        if (u == 0) probe_flag("R7");
                        else if (t == "R3") probe_flag("R4");
                        else probe_flag(t);
                    end
                end
            end
        end

        // R6: immediate path ignores the code and keeps the flag
        for (int f = 0; f < 2; f++) begin
            for (int k = 0; k < 6; k++) begin
                for (int p = 0; p < 8; p++) begin
                    logic [31:0] got;
                    force_flag(f[0]);
                    run_op(5'((p * 5 + k) % 32), pa[p], pb[p], 1'b1, 1'b1, iv[k], "R6", got);
                    probe_flag("R6");
                end
            end
        end

        // R9: chained 64-bit add and subtract across two instructions
        for (int p = 0; p < 8; p++) begin
            x = {pa[p], pb[7 - p]};
            y = {pb[p], pa[(p + 3) % 8]};
            force_flag(p[0]);
            run_op(5'd0, x[31:0], y[31:0], 1'b1, 1'b0, 18'd0, "R9", lo);
            run_op(5'd1, x[63:32], y[63:32], 1'b1, 1'b0, 18'd0, "R9", hi);
            check32("R9", "64-bit sum high", hi, 32'((x + y) >> 32));
            check32("R9", "64-bit sum low", lo, 32'(x + y));
            force_flag(~p[0]);
            run_op(5'd2, x[31:0], y[31:0], 1'b1, 1'b0, 18'd0, "R9", lo);
            run_op(5'd3, x[63:32], y[63:32], 1'b1, 1'b0, 18'd0, "R9", hi);
            check32("R9", "64-bit diff high", hi, 32'((x - y) >> 32));
            check32("R9", "64-bit diff low", lo, 32'(x - y));
            probe_flag("R9");
        end

        // R8: reset in mid-run clears a set flag
        force_flag(1'b1);
        probe_flag("R8");
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_flag = 1'b0;
        probe_flag("R8");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule